// File: doc/BRIEF.md
# Block-transfer request framer and capability responder

This block is the message layer behind a block-transfer style host mailbox. The host fills an inbound byte buffer and then raises a request event. The block checks the frame in that buffer: a leading length byte, a function-code byte, a sequence byte and a command byte. One command, the interface-capabilities query, is answered inside the block. Every other request is passed on to a command backend as a valid/ready byte stream, and a rolling tag travels with it in place of the host sequence number.

The backend sends its reply back as a tagged byte stream. A reply whose tag matches the outstanding tag is framed into the outbound buffer with the saved host sequence number restored. If the reply is too large for the outbound buffer, a short error frame is built instead. Once any reply is complete, the block drops its busy flag and raises attention towards the host. The host reads the outbound buffer through a plain read port, using the committed length.

Top module: `bt_msg_engine`

## Requirements
- R1: A request event while fewer than 4 inbound bytes are held is ignored: busy stays as it was, nothing is forwarded and the outbound length is unchanged.
- R2: A request whose byte 0 differs from (inbound count - 1) is discarded. The inbound count is cleared, so a repeated event with no new bytes is also ignored. Busy stays set and nothing is forwarded.
- R3: Function byte 0x18 (byte 1) together with command 0x36 (byte 3) produces a local 10-byte reply: 9, byte1|0x04, byte2, 0x36, 0x00, 0x01, min(IN_DEPTH,255), min(OUT_DEPTH,255), 10, 0. The outbound length becomes 10, and nothing is forwarded.
- R4: Any other valid request is forwarded as byte 1 followed by bytes 3 up to the last stored byte, with fwd_last on the final beat. Data stays stable while it is stalled.
- R5: A response is taken only if the tag on its first beat equals fwd_tag. Otherwise the whole packet is consumed and dropped, leaving busy, attention and the outbound buffer as they were.
- R6: The tag starts at 0 after reset and goes up by exactly 1 for each accepted response. The capability reply leaves it unchanged.
- R7: An accepted response of N bytes (function, command, data) with N <= OUT_DEPTH-2 is framed as N+1, function, saved byte 2, then command and data. The outbound length becomes N+2.
- R8: An accepted response with N > OUT_DEPTH-2 gives the 5-byte frame 4, function, saved byte 2, command, 0xCA, with outbound length 5.
- R9: When a reply is committed, busy clears and attention sets in the same cycle as the length update. A pulse on atn_clr clears attention.
- R10: After reset, busy, attention, outbound length and fwd_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_we | input | 1 | Append one byte to the inbound buffer |
| in_wdata | input | 8 | Inbound byte |
| in_clr | input | 1 | Clear the inbound count |
| req_go | input | 1 | Request event pulse |
| atn_clr | input | 1 | Clear the host attention flag |
| out_rd_addr | input | $clog2(OUT_DEPTH) | Outbound buffer read index |
| out_rd_data | output | 8 | Outbound byte at out_rd_addr |
| out_len | output | $clog2(OUT_DEPTH+1) | Committed outbound length |
| bmc_busy | output | 1 | Controller-busy flag |
| b2h_atn | output | 1 | Reply-ready attention to host |
| fwd_valid | output | 1 | Forward stream valid |
| fwd_ready | input | 1 | Forward stream ready |
| fwd_data | output | 8 | Forward stream byte |
| fwd_last | output | 1 | Final forward byte |
| fwd_tag | output | 8 | Tag of the outstanding request |
| rsp_valid | input | 1 | Response stream valid |
| rsp_ready | output | 1 | Response stream ready |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Final response byte |
| rsp_tag | input | 8 | Response tag, sampled on the first beat |

## Verification
The assertions assume the host does not touch the inbound buffer while a request is in flight. They also assume the backend holds a response tag steady for the length of its packet and sends responses only after the forward stream has ended. The bench follows these rules. It clears and refills the inbound buffer only while the block is idle. It collects each complete forward packet before it drives a response. Before each good response it sends one packet with a wrong tag, all with a constant tag per packet.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CHK, S_HDR, S_CAP, S_FWD, S_RSP, S_FIN
  } bt_st_e;

  localparam logic [7:0] FN_APP_REQ  = 8'h18;
  localparam logic [7:0] CMD_CAPS    = 8'h36;
  localparam logic [7:0] FN_RSP_BIT  = 8'h04;
  localparam logic [7:0] CC_TOO_BIG  = 8'hCA;
  localparam logic [7:0] CAP_RSP_T   = 8'd10;
  localparam int         MIN_REQ     = 4;

  function automatic logic [7:0] sat_byte(input int v);
    return (v > 255) ? 8'hFF : 8'(v);
  endfunction
endpackage

// File: rtl/bt_byte_ram.sv
module bt_byte_ram #(
  parameter int DEPTH = 16,
  parameter int NRD   = 1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] rd_addr [NRD],
  output logic [7:0]    rd_data [NRD]
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = mem[rd_addr[g]];
  end
endmodule

// File: rtl/bt_msg_ctrl.sv
module bt_msg_ctrl
  import bt_pkg::*;
#(
  parameter int IN_DEPTH  = 16,
  parameter int OUT_DEPTH = 12,
  localparam int IA_W  = $clog2(IN_DEPTH),
  localparam int OA_W  = $clog2(OUT_DEPTH),
  localparam int OL_W  = $clog2(OUT_DEPTH + 1),
  localparam int CNT_W = IA_W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_we,
  input  logic            in_clr,
  input  logic            req_go,
  input  logic            atn_clr,
  output logic            iwe,
  output logic [IA_W-1:0] iwaddr,
  output logic [IA_W-1:0] ira,
  output logic [IA_W-1:0] irb,
  input  logic [7:0]      ida,
  input  logic [7:0]      idb,
  output logic            owe,
  output logic [OA_W-1:0] owaddr,
  output logic [7:0]      owdata,
  output logic [OL_W-1:0] out_len,
  output logic            bmc_busy,
  output logic            b2h_atn,
  output logic            fwd_valid,
  input  logic            fwd_ready,
  output logic [7:0]      fwd_data,
  output logic            fwd_last,
  output logic [7:0]      fwd_tag,
  input  logic            rsp_valid,
  output logic            rsp_ready,
  input  logic [7:0]      rsp_data,
  input  logic            rsp_last,
  input  logic [7:0]      rsp_tag
);
  localparam logic [CNT_W-1:0] CNT_DEPTH = CNT_W'(IN_DEPTH);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] CNT_MIN   = CNT_W'(MIN_REQ);
  localparam logic [7:0]       LAST_FULL = 8'(IN_DEPTH - 1);
  localparam logic [7:0]       BIG_LIM   = 8'(OUT_DEPTH - 2);
  localparam logic [8:0]       ODEP9     = 9'(OUT_DEPTH);
  localparam logic [7:0]       IN_SZ     = sat_byte(IN_DEPTH);
  localparam logic [7:0]       OUT_SZ    = sat_byte(OUT_DEPTH);

  bt_st_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       idx_q, idx_d, fn_q, fn_d, seq_q, seq_d, tag_q, tag_d, n_q, n_d;
  logic             busy_q, busy_d, atn_q, atn_d, drop_q, drop_d;
  logic [OL_W-1:0]  len_q, len_d;
  logic [7:0]       last_idx, cap_byte;
  logic             len_bad, big, tag_ok;

  assign last_idx = (cnt_q >= CNT_DEPTH) ? LAST_FULL : 8'(cnt_q) - 8'd1;
  assign len_bad  = (ida != 8'(cnt_q) - 8'd1);
  assign big      = (n_q > BIG_LIM);
  assign tag_ok   = (idx_q == 8'd0) ? (rsp_tag == tag_q) : !drop_q;
  assign iwe      = in_we && !in_clr && (cnt_q < CNT_DEPTH);
  assign iwaddr   = cnt_q[IA_W-1:0];

  always_comb begin
    case (idx_q)
      8'd0: cap_byte = 8'd9;
      8'd1: cap_byte = fn_q | FN_RSP_BIT;
      8'd2: cap_byte = seq_q;
      8'd3: cap_byte = CMD_CAPS;
      8'd5: cap_byte = 8'd1;
      8'd6: cap_byte = IN_SZ;
      8'd7: cap_byte = OUT_SZ;
      8'd8: cap_byte = CAP_RSP_T;
      default: cap_byte = 8'd0;
    endcase
  end

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; idx_d = idx_q; fn_d = fn_q; seq_d = seq_q;
    tag_d = tag_q; n_d = n_q; busy_d = busy_q; atn_d = atn_q; drop_d = drop_q;
    len_d = len_q;
    ira = '0; irb = IA_W'(1);
    owe = 1'b0; owaddr = '0; owdata = 8'd0;
    fwd_valid = 1'b0; fwd_data = 8'd0; fwd_last = 1'b0; rsp_ready = 1'b0;

    if (in_clr)                          cnt_d = '0;
    else if (in_we && cnt_q != CNT_MAX)  cnt_d = cnt_q + 1'b1;
    if (atn_clr) atn_d = 1'b0;

    case (st_q)
      S_IDLE: if (req_go && cnt_q >= CNT_MIN) begin
        busy_d = 1'b1; st_d = S_CHK;
      end
      S_CHK: begin
        if (len_bad) begin cnt_d = '0; st_d = S_IDLE; end
        else begin fn_d = idb; st_d = S_HDR; end
      end
      S_HDR: begin
        ira = IA_W'(2); irb = IA_W'(3);
        seq_d = ida;
        if (fn_q == FN_APP_REQ && idb == CMD_CAPS) begin
          idx_d = 8'd0; st_d = S_CAP;
        end else begin
          idx_d = 8'd2; st_d = S_FWD;
        end
      end
      S_CAP: begin
        owe = 1'b1; owaddr = idx_q[OA_W-1:0]; owdata = cap_byte;
        if (idx_q == 8'd9) begin
          len_d = OL_W'(10); busy_d = 1'b0; atn_d = 1'b1; st_d = S_IDLE;
        end else idx_d = idx_q + 8'd1;
      end
      S_FWD: begin
        ira = idx_q[IA_W-1:0];
        fwd_valid = 1'b1;
        fwd_data  = (idx_q == 8'd2) ? fn_q : ida;
        fwd_last  = (idx_q == last_idx);
        if (fwd_ready) begin
          if (fwd_last) begin idx_d = 8'd0; drop_d = 1'b0; st_d = S_RSP; end
          else idx_d = idx_q + 8'd1;
        end
      end
      S_RSP: begin
        rsp_ready = 1'b1;
        if (rsp_valid) begin
          drop_d = !tag_ok;
          if (tag_ok && (idx_q == 8'd0 || {1'b0, idx_q} + 9'd2 < ODEP9)) begin
            owe    = 1'b1;
            owaddr = (idx_q == 8'd0) ? OA_W'(1) : OA_W'(idx_q + 8'd2);
            owdata = rsp_data;
          end
          if (idx_q != 8'hFF) idx_d = idx_q + 8'd1;
          if (rsp_last) begin
            idx_d = 8'd0;
            if (tag_ok) begin n_d = idx_q + 8'd1; st_d = S_FIN; end
          end
        end
      end
      S_FIN: begin
        idx_d = idx_q + 8'd1;
        case (idx_q)
          8'd0: begin owe = 1'b1; owaddr = OA_W'(2); owdata = seq_q; end
          8'd1: begin owe = big; owaddr = OA_W'(4); owdata = CC_TOO_BIG; end
          default: begin
            owe = 1'b1; owaddr = '0;
            owdata = big ? 8'd4 : n_q + 8'd1;
            len_d  = big ? OL_W'(5) : OL_W'(n_q + 8'd2);
            busy_d = 1'b0; atn_d = 1'b1; tag_d = tag_q + 8'd1;
            idx_d  = 8'd0; st_d = S_IDLE;
          end
        endcase
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; idx_q <= 8'd0; fn_q <= 8'd0; seq_q <= 8'd0;
      tag_q <= 8'd0; n_q <= 8'd0; busy_q <= 1'b0; atn_q <= 1'b0;
      drop_q <= 1'b0; len_q <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; idx_q <= idx_d; fn_q <= fn_d; seq_q <= seq_d;
      tag_q <= tag_d; n_q <= n_d; busy_q <= busy_d; atn_q <= atn_d;
      drop_q <= drop_d; len_q <= len_d;
    end
  end

  assign out_len  = len_q;
  assign bmc_busy = busy_q;
  assign b2h_atn  = atn_q;
  assign fwd_tag  = tag_q;

  p_short_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && req_go && cnt_q < CNT_MIN) |=> (st_q == S_IDLE && $stable(busy_q)));
  p_discard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CHK && len_bad) |=> (busy_q && cnt_q == '0 && st_q == S_IDLE));
  p_fwd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_data) && $stable(fwd_last)));
  p_tag_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tag_q) |-> (tag_q == $past(tag_q) + 8'd1));
  p_len_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= OL_W'(OUT_DEPTH));
  p_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(len_q) |-> (atn_q && !busy_q));
endmodule

// File: rtl/bt_msg_engine.sv
module bt_msg_engine #(
  parameter int IN_DEPTH  = 16,
  parameter int OUT_DEPTH = 12,
  localparam int IA_W = $clog2(IN_DEPTH),
  localparam int OA_W = $clog2(OUT_DEPTH),
  localparam int OL_W = $clog2(OUT_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_we,
  input  logic [7:0]      in_wdata,
  input  logic            in_clr,
  input  logic            req_go,
  input  logic            atn_clr,
  input  logic [OA_W-1:0] out_rd_addr,
  output logic [7:0]      out_rd_data,
  output logic [OL_W-1:0] out_len,
  output logic            bmc_busy,
  output logic            b2h_atn,
  output logic            fwd_valid,
  input  logic            fwd_ready,
  output logic [7:0]      fwd_data,
  output logic            fwd_last,
  output logic [7:0]      fwd_tag,
  input  logic            rsp_valid,
  output logic            rsp_ready,
  input  logic [7:0]      rsp_data,
  input  logic            rsp_last,
  input  logic [7:0]      rsp_tag
);
  logic            iwe, owe;
  logic [IA_W-1:0] iwaddr, ira, irb;
  logic [OA_W-1:0] owaddr;
  logic [7:0]      ida, idb, owdata;
  logic [IA_W-1:0] in_ra [2];
  logic [7:0]      in_rd [2];
  logic [OA_W-1:0] out_ra [1];
  logic [7:0]      out_rd [1];

  assign in_ra[0]    = ira;
  assign in_ra[1]    = irb;
  assign ida         = in_rd[0];
  assign idb         = in_rd[1];
  assign out_ra[0]   = out_rd_addr;
  assign out_rd_data = out_rd[0];

  bt_byte_ram #(.DEPTH(IN_DEPTH), .NRD(2)) u_in_ram (
    .clk(clk), .we(iwe), .waddr(iwaddr), .wdata(in_wdata),
    .rd_addr(in_ra), .rd_data(in_rd));

  bt_byte_ram #(.DEPTH(OUT_DEPTH), .NRD(1)) u_out_ram (
    .clk(clk), .we(owe), .waddr(owaddr), .wdata(owdata),
    .rd_addr(out_ra), .rd_data(out_rd));

  bt_msg_ctrl #(.IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_we(in_we), .in_clr(in_clr), .req_go(req_go),
    .atn_clr(atn_clr), .iwe(iwe), .iwaddr(iwaddr), .ira(ira), .irb(irb),
    .ida(ida), .idb(idb), .owe(owe), .owaddr(owaddr), .owdata(owdata),
    .out_len(out_len), .bmc_busy(bmc_busy), .b2h_atn(b2h_atn),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_data(fwd_data),
    .fwd_last(fwd_last), .fwd_tag(fwd_tag), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .rsp_tag(rsp_tag));
endmodule

// File: tb/bt_msg_engine_tb_top.sv
module bt_msg_engine_tb_top;
  localparam int IN_DEPTH = 16, OUT_DEPTH = 12;
  localparam int OA_W = $clog2(OUT_DEPTH), OL_W = $clog2(OUT_DEPTH + 1);
  localparam int NV = 5;
  localparam int VEC [NV][2] = '{'{4, 2}, '{6, 5}, '{12, 10}, '{5, 11}, '{16, 3}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_we = 0, in_clr = 0, req_go = 0, atn_clr = 0, fwd_ready = 1;
  logic rsp_valid = 0, rsp_last = 0;
  logic [7:0] in_wdata = 0, rsp_data = 0, rsp_tag = 0;
  logic [OA_W-1:0] out_rd_addr = '0;
  logic [7:0] out_rd_data, fwd_data, fwd_tag;
  logic [OL_W-1:0] out_len;
  logic bmc_busy, b2h_atn, fwd_valid, fwd_last, rsp_ready;
  int total = 0, bad = 0;
  logic [7:0] fbuf [32];
  int fcnt, ftag, flast_ok;

  always #5 clk = ~clk;

  bt_msg_engine #(.IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)) dut_i (.*);

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); in_clr = 1; @(negedge clk); in_clr = 0;
  endtask
  task automatic pulse_go();
    @(negedge clk); req_go = 1; @(negedge clk); req_go = 0;
  endtask
  task automatic pulse_atn_clr();
    @(negedge clk); atn_clr = 1; @(negedge clk); atn_clr = 0;
  endtask
  task automatic wr(input logic [7:0] b);
    @(negedge clk); in_we = 1; in_wdata = b; @(negedge clk); in_we = 0;
  endtask
  task automatic rd(input int a, output int v);
    out_rd_addr = OA_W'(a); #1; v = out_rd_data;
  endtask

  // Counts forward beats over n cycles (used where nothing may be forwarded).
  task automatic watch_fwd(input int n, output int seen);
    seen = 0;
    repeat (n) begin @(negedge clk); if (fwd_valid) seen++; end
  endtask

  task automatic collect();
    fcnt = 0; ftag = -1; flast_ok = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (fwd_valid) begin
        fbuf[fcnt] = fwd_data; ftag = fwd_tag; fcnt++;
        if (fwd_last) begin flast_ok = 1; break; end
      end
    end
  endtask

  task automatic send_rsp(input logic [7:0] tg, input int m, input int i, input logic [7:0] r0);
    for (int k = 0; k < m; k++) begin
      @(negedge clk);
      rsp_valid = 1; rsp_tag = tg; rsp_last = (k == m - 1);
      rsp_data = (k == 0) ? r0 : (k == 1) ? 8'(8'h60 + i) : 8'(8'hC0 + k + i);
    end
    @(negedge clk); rsp_valid = 0; rsp_last = 0;
  endtask

  task automatic wait_atn();
    for (int c = 0; c < 20; c++) begin
      if (b2h_atn) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=expired exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, seen, n, m, prev_len;
    logic [7:0] fn, r0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "busy", bmc_busy, 0);
    chk("R10", "atn", b2h_atn, 0);
    chk("R10", "out_len", out_len, 0);
    chk("R10", "fwd_valid", fwd_valid, 0);

    // R1 short request
    pulse_clr(); wr(8'd2); wr(8'h20); wr(8'h01);
    pulse_go(); watch_fwd(8, seen);
    chk("R1", "forwarded beats", seen, 0);
    chk("R1", "busy", bmc_busy, 0);
    chk("R1", "out_len", out_len, 0);

    // R2 length mismatch, then a repeated event with no new bytes
    pulse_clr(); wr(8'd7); wr(8'h20); wr(8'h01); wr(8'h02); wr(8'h03);
    pulse_go(); watch_fwd(8, seen);
    chk("R2", "forwarded beats", seen, 0);
    chk("R2", "busy held", bmc_busy, 1);
    pulse_go(); watch_fwd(8, seen);
    chk("R2", "count cleared, repeat ignored", seen, 0);
    chk("R2", "out_len", out_len, 0);

    // R3 local capability reply
    pulse_clr(); wr(8'd3); wr(8'h18); wr(8'h55); wr(8'h36);
    pulse_go(); watch_fwd(16, seen);
    chk("R3", "forwarded beats", seen, 0);
    chk("R3", "out_len", out_len, 10);
    chk("R9", "busy after cap", bmc_busy, 0);
    chk("R9", "atn after cap", b2h_atn, 1);
    begin
      int exp_cap [10];
      exp_cap = '{9, 8'h1C, 8'h55, 8'h36, 0, 1, IN_DEPTH, OUT_DEPTH, 10, 0};
      for (int k = 0; k < 10; k++) begin
        rd(k, v); chk("R3", $sformatf("cap byte %0d", k), v, exp_cap[k]);
      end
    end
    pulse_atn_clr();
    chk("R9", "atn cleared", b2h_atn, 0);

    // Vector walk: forward, wrong-tag drop, framing, oversize
    for (int i = 0; i < NV; i++) begin
      n = VEC[i][0]; m = VEC[i][1];
      fn = 8'(8'h28 + 4 * i);
      r0 = fn | 8'h04;
      pulse_clr();
      for (int j = 0; j < n; j++)
        wr((j == 0) ? 8'(n - 1) : (j == 1) ? fn : (j == 2) ? 8'(8'h40 + i) :
           (j == 3) ? 8'(8'h60 + i) : 8'(8'h80 + j + 16 * i));
      pulse_go();
      collect();
      chk("R4", $sformatf("v%0d beats", i), fcnt, n - 2);
      chk("R4", $sformatf("v%0d last", i), flast_ok, 1);
      chk("R6", $sformatf("v%0d tag", i), ftag, i);
      for (int k = 0; k < fcnt && k < n - 2; k++)
        chk("R4", $sformatf("v%0d beat %0d", i, k), fbuf[k],
            (k == 0) ? fn : (k == 1) ? 8'(8'h60 + i) : 8'(8'h80 + k + 2 + 16 * i));
      prev_len = out_len;
      send_rsp(8'(i + 1), 3, 7, 8'hEE);
      repeat (4) @(negedge clk);
      chk("R5", $sformatf("v%0d busy after bad tag", i), bmc_busy, 1);
      chk("R5", $sformatf("v%0d atn after bad tag", i), b2h_atn, 0);
      chk("R5", $sformatf("v%0d len after bad tag", i), out_len, prev_len);
      send_rsp(8'(i), m, i, r0);
      wait_atn();
      chk("R9", $sformatf("v%0d atn", i), b2h_atn, 1);
      chk("R9", $sformatf("v%0d busy", i), bmc_busy, 0);
      if (m > OUT_DEPTH - 2) begin
        int e8 [5];
        e8 = '{4, r0, 8'h40 + i, 8'h60 + i, 8'hCA};
        chk("R8", $sformatf("v%0d len", i), out_len, 5);
        for (int k = 0; k < 5; k++) begin
          rd(k, v); chk("R8", $sformatf("v%0d byte %0d", i, k), v, e8[k]);
        end
      end else begin
        chk("R7", $sformatf("v%0d len", i), out_len, m + 2);
        for (int k = 0; k < m + 2; k++) begin
          rd(k, v);
          chk("R7", $sformatf("v%0d byte %0d", i, k), v,
              (k == 0) ? m + 1 : (k == 1) ? r0 : (k == 2) ? 8'h40 + i :
              (k == 3) ? 8'h60 + i : 8'hC0 + (k - 2) + i);
        end
      end
      pulse_atn_clr();
    end
    chk("R6", "final tag", fwd_tag, NV);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule